// File: doc/BRIEF.md
# Host Bridge Control Register File

This block is the bank of control words that a host bridge keeps for software: twenty-eight 32-bit words covering configuration, general-purpose pin control, interrupt routing, mailboxes and cache control. It is reached through a simple request port (valid, write, byte address, write data). A read returns its word one cycle later. All words load fixed values on reset. The logic that uses these values sits elsewhere.

Three words behave differently from plain storage. One write-only port word ORs its value into the interrupt enable word, and another clears the matching bits of that word. The enable word and the status word cannot be written from the port. A rising edge on one bit of the general configuration word, caused by a write, raises a one-cycle system reset request.

Top module: `hostbr_regfile`

## Requirements
- R1: After reset, a read of byte offset 0x00 returns 0xC40, 0x04 returns 0x1384, 0x08 returns 0x2BFF8010, 0x0C returns 0x255E0091, 0x10 returns 0x6140, 0x1C and 0x20 return 0x1FF, 0x68 returns 0x8, 0x6C returns 0x10000000, and every other offset up to 0x6C returns 0.
- R2: A write to any word at offsets 0x00 to 0x6C, other than 0x38 and 0x3C, stores all 32 bits. The word index is the byte address shifted right by 2, so address bits [1:0] are ignored.
- R3: A read presented with busValid=1 and busWrite=0 drives busRdata and a one-cycle rdValid=1 on the following cycle. Any offset above 0x6C reads as 0.
- R4: A write to any offset above 0x6C changes no word.
- R5: A write to offset 0x30 stores the value at 0x30 and ORs it into the enable word at 0x38.
- R6: A write to offset 0x34 stores the value at 0x34 and clears, in the enable word at 0x38, every bit that is 1 in the value.
- R7: Writes to the enable word (0x38) and the status word (0x3C) are ignored. The status word reads 0.
- R8: A write to offset 0x04 whose data has bit 2 set, while the stored bit 2 is 0, raises rstReq for exactly one cycle, on the cycle after the write. The new value is stored.
- R9: A write to offset 0x04 raises no rstReq when the stored bit 2 is already 1 or the new bit 2 is 0. The value is still stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Request present this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (8) | Byte address; bits [1:0] ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data returned this cycle |
| rstReq | output | 1 | One-cycle system reset request |

## Verification
The embedded assertions check the following on every cycle:
- The enable word changes only after a set or clear alias write, and it reflects that write afterwards.
- rstReq is a lone pulse that always traces back to a zero-to-one write of the reset bit.
- rdValid follows each read by exactly one cycle.

Only the bench's scenarios can show the rest:
- The exact reset values.
- The full address map, including aliasing of the low address bits.
- That out-of-range and read-only writes leave every word untouched.

The bench does this by sweeping every word index of the 8-bit address space with computed data and then reading the whole space back.

// File: rtl/hostbr_pkg.sv
package hostbr_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_WORDS = 28;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  // word indices whose behaviour differs from plain storage
  localparam int IDX_GENCFG  = 1;
  localparam int IDX_ENSET   = 12;
  localparam int IDX_ENCLR   = 13;
  localparam int IDX_ENABLE  = 14;
  localparam int IDX_STATUS  = 15;
  localparam int SOFTRST_BIT = 2;

  typedef struct packed {
    logic              wrStore;  // store data into word idx
    logic              wrSet;    // OR data into enable word
    logic              wrClr;    // clear data bits in enable word
    logic              wrGen;    // write to general config word
    logic              rdEn;     // read request
    logic              rdHit;    // read request inside the map
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } strobe_t;

  function automatic logic [DATA_W-1:0] resetWord(input int idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/hostbr_ctrl.sv
module hostbr_ctrl
  import hostbr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  output strobe_t             st
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic              inRange;
  logic              wrAny;
  logic [IDX_W-1:0]  idx;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign inRange = (32'(wordIdx) < NUM_WORDS);
  assign idx     = wordIdx[IDX_W-1:0];
  assign wrAny   = busValid && busWrite && inRange;

  always_comb begin
    st         = '0;
    st.idx     = idx;
    st.data    = busWdata;
    st.wrSet   = wrAny && (idx == IDX_W'(IDX_ENSET));
    st.wrClr   = wrAny && (idx == IDX_W'(IDX_ENCLR));
    st.wrGen   = wrAny && (idx == IDX_W'(IDX_GENCFG));
    st.wrStore = wrAny && (idx != IDX_W'(IDX_ENABLE)) && (idx != IDX_W'(IDX_STATUS));
    st.rdEn    = busValid && !busWrite;
    st.rdHit   = busValid && !busWrite && inRange;
  end
endmodule

// File: rtl/hostbr_dpath.sv
module hostbr_dpath
  import hostbr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  output logic [DATA_W-1:0] busRdata,
  output logic              rdValid,
  output logic              rstReq
);
  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [DATA_W-1:0] rdMux;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    logic [DATA_W-1:0] q;
    if (i == IDX_STATUS) begin : g_status
      assign q = '0;
    end else if (i == IDX_ENABLE) begin : g_enable
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         q <= resetWord(i);
        else if (st.wrSet) q <= q | st.data;
        else if (st.wrClr) q <= q & ~st.data;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                    q <= resetWord(i);
        else if (st.wrStore && st.idx == IDX_W'(i))   q <= st.data;
      end
    end
    assign words[i] = q;
  end

  always_comb begin
    rdMux = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (st.idx == IDX_W'(k)) rdMux = words[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
      rdValid  <= 1'b0;
      rstReq   <= 1'b0;
    end else begin
      rdValid <= st.rdEn;
      if (st.rdEn) busRdata <= st.rdHit ? rdMux : '0;
      rstReq  <= st.wrGen && st.data[SOFTRST_BIT] && !words[IDX_GENCFG][SOFTRST_BIT];
    end
  end

  // assertions
  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  a_r7_enable_ro: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(st.wrSet) && !$past(st.wrClr)) |-> $stable(words[IDX_ENABLE]));

  a_r5_set_or: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(st.wrSet)) |-> ((words[IDX_ENABLE] & $past(st.data)) == $past(st.data)));

  a_r6_clr_bits: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(st.wrClr)) |-> ((words[IDX_ENABLE] & $past(st.data)) == '0));

  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  a_r8_req_cause: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && rstReq) |-> ($past(st.wrGen) && $past(st.data[SOFTRST_BIT])
                               && !words[IDX_GENCFG][SOFTRST_BIT] == 1'b0));

  a_r3_rd_latency: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> (rdValid == $past(st.rdEn)));
endmodule

// File: rtl/hostbr_regfile.sv
module hostbr_regfile
  import hostbr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              rdValid,
  output logic              rstReq
);
  strobe_t st;

  hostbr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .st       (st)
  );

  hostbr_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .busRdata (busRdata),
    .rdValid  (rdValid),
    .rstReq   (rstReq)
  );
endmodule

// File: tb/hostbr_regfile_bench.sv
module hostbr_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int SPACE      = 1 << (ADDR_W - 2);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              rdValid;
  logic              rstReq;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] model [28];
  logic        lastReq;

  always #(CLK_PERIOD/2) clk = ~clk;

  hostbr_regfile #(.ADDR_W(ADDR_W)) u_hostbr_regfile (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rdValid(rdValid), .rstReq(rstReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] defVal(input int i);
    logic [31:0] v = 0;
    if (i == 0)  v = 32'hC40;
    if (i == 1)  v = 32'h1384;
    if (i == 2)  v = 32'h2BFF8010;
    if (i == 3)  v = 32'h255E0091;
    if (i == 4)  v = 32'h6140;
    if (i == 7 || i == 8) v = 32'h1FF;
    if (i == 26) v = 32'h8;
    if (i == 27) v = 32'h10000000;
    return v;
  endfunction

  // model update; returns expected reset request
  function automatic logic modelWrite(input int i, input logic [31:0] d);
    logic req = 1'b0;
    if (i < 28 && i != 14 && i != 15) begin
      if (i == 1) req = !model[1][2] && d[2];
      model[i] = d;
      if (i == 12) model[14] = model[14] | d;
      if (i == 13) model[14] = model[14] & ~d;
    end
    return req;
  endfunction

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    lastReq = rstReq;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata; v = rdValid;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    testsFailed++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        rv;
    logic        expReq;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 28; i++) model[i] = defVal(i);

    // R1 reset values, R3 latency and valid flag
    chk("R1 reqIdle", {31'b0, rstReq}, 32'b0);
    for (int i = 0; i < 28; i++) begin
      doRead(ADDR_W'(i * 4), rd, rv);
      chk("R1 default", rd, defVal(i));
      chk("R3 rdValid", {31'b0, rv}, 32'b1);
    end
    @(negedge clk);
    chk("R3 rdValid drops", {31'b0, rdValid}, 32'b0);

    // R9 bit already set, R8 rising edge, R9 bit cleared then rewritten
    doWrite(8'h04, 32'h0000_1384);
    chk("R9 no req bit set", {31'b0, lastReq}, 32'b0);
    doWrite(8'h04, 32'h0000_1380);
    chk("R9 no req bit 0", {31'b0, lastReq}, 32'b0);
    doWrite(8'h04, 32'hABCD_0004);
    chk("R8 req pulse", {31'b0, lastReq}, 32'b1);
    @(negedge clk);
    chk("R8 single cycle", {31'b0, rstReq}, 32'b0);
    doRead(8'h04, rd, rv);
    chk("R8 value stored", rd, 32'hABCD_0004);
    model[1] = 32'hABCD_0004;

    // R5 / R6 aliases, R7 read-only words
    void'(modelWrite(12, 32'h0F0F_00FF));
    doWrite(8'h30, 32'h0F0F_00FF);
    doRead(8'h38, rd, rv);
    chk("R5 enable or", rd, 32'h0F0F_00FF);
    doRead(8'h30, rd, rv);
    chk("R5 set stored", rd, 32'h0F0F_00FF);
    void'(modelWrite(13, 32'h0303_000F));
    doWrite(8'h34, 32'h0303_000F);
    doRead(8'h38, rd, rv);
    chk("R6 enable clear", rd, 32'h0C0C_00F0);
    doRead(8'h34, rd, rv);
    chk("R6 clr stored", rd, 32'h0303_000F);
    doWrite(8'h38, 32'hFFFF_FFFF);
    doRead(8'h38, rd, rv);
    chk("R7 enable ro", rd, 32'h0C0C_00F0);
    doWrite(8'h3C, 32'h1234_5678);
    doRead(8'h3C, rd, rv);
    chk("R7 status ro", rd, 32'h0);

    // sweep: write every word index of the space, low address bits varied (R2, R4)
    for (int i = 0; i < SPACE; i++) begin
      logic [31:0] d;
      d = 32'h9E37_79B9 * (i + 1) ^ 32'h0000_0004 * (i % 2);
      expReq = modelWrite(i, d);
      doWrite(ADDR_W'(i * 4 + (i % 4)), d);
      chk("R8 R9 sweep req", {31'b0, lastReq}, {31'b0, expReq});
    end
    for (int i = 0; i < SPACE; i++) begin
      doRead(ADDR_W'(i * 4 + ((i + 1) % 4)), rd, rv);
      if (i < 28) chk("R2 R5 R6 R7 sweep read", rd, model[i]);
      else        chk("R3 R4 out of range", rd, 32'h0);
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule